// File: doc/BRIEF.md
# Capture Timer with Deferred Wrap Status

This block is one timer channel. A free-running up-counter advances once per clock while the count enable is high. A capture strobe copies the counter into a capture register. The block also keeps a one-bit wrap flag, reported in bit 0 of an 8-bit read-only status byte. The flag does not follow the counter: a wrap is remembered in a hidden pending bit. Only the next capture resolves it, and that capture writes into the flag whether the counter wrapped since the previous capture.

A 3-bit mode input selects the behaviour. Two modes maintain the flag:

- Free capture (3'b010): captures at any time and restarts the counter from zero.
- Single-shot capture (3'b110): the counter waits for a start strobe, runs until one capture, and then halts at zero.

In every other mode the counter still counts, but captures are ignored and the flag is frozen.

Top module: `capture_timer`

## Requirements
- R1: Outside modes 3'b010 and 3'b110, a capture strobe changes neither the capture output nor the status byte, and the flag keeps its last value.
- R2: Bits 7 to 1 of the status byte always read zero, and bit 0 is the wrap flag.
- R3: After reset the status byte reads 8'h00 and the capture output reads zero.
- R4: A counter wrap from all-ones to zero leaves the status byte unchanged until a capture is taken.
- R5: A capture taken after a wrap since the previous capture sets bit 0 of the status byte in the following cycle.
- R6: A capture taken with no wrap since the previous capture clears bit 0, even when it was 1.
- R7: In mode 3'b010 the counter starts at zero and rises by one per clock with count enable high. It holds while enable is low. A capture outputs the count and restarts the counter at zero.
- R8: A wrap in the same clock as a capture counts toward that capture: the capture output is all-ones and the flag is set.
- R9: In mode 3'b110 the counter stays at zero until a start strobe. After one capture it halts at zero again. A capture strobe while halted is ignored.
- R10: Time spent in a mode other than 3'b010 or 3'b110 discards any wrap not yet resolved, so the first capture after returning to a capture mode clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Operating mode select |
| cntEn | input | 1 | Count enable, one step per clock while high |
| capStb | input | 1 | Capture request, one clock wide |
| startStb | input | 1 | Start request for single-shot capture |
| capData | output | CNT_W (16) | Last captured count |
| status | output | 8 | Status byte, wrap flag in bit 0 |

## Verification
Every result of a capture, both the captured count and the resolved flag, appears at the ports one clock after the edge that samples the capture strobe. The counter value taken equals the number of enabled edges since the last restart. Stimulus changes on the falling edge. The monitor notes a strobe at the rising edge, waits three nanoseconds, and then compares both outputs with the item the driver queued for that strobe. Ignored captures also queue an item, in which both outputs are unchanged. The bench checks that the flag stays put after a wrap by sampling the status byte between the wrap and the next capture.

// File: rtl/capture_timer_pkg.sv
package capture_timer_pkg;
  localparam logic [2:0] MODE_CAP     = 3'b010;
  localparam logic [2:0] MODE_CAP_ONE = 3'b110;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic capLoad;
  } tmrStrobe_t;
endpackage

// File: rtl/capture_timer_ctrl.sv
module capture_timer_ctrl
  import capture_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       cntEn,
  input  logic       capStb,
  input  logic       startStb,
  input  logic       cntMax,
  output tmrStrobe_t stb,
  output logic       wrapNow,
  output logic       wrapFlag
);
  logic isCap, isOne, capMode, running, pending, countOk;

  assign isCap   = (mode == MODE_CAP);
  assign isOne   = (mode == MODE_CAP_ONE);
  assign capMode = isCap | isOne;
  assign countOk = isOne ? running : 1'b1;

  always_comb begin
    stb.cntInc  = cntEn & countOk;
    stb.capLoad = capStb & (isCap | (isOne & running));
    stb.cntClr  = stb.capLoad;
  end

  assign wrapNow = stb.cntInc & cntMax;

  // single-shot run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           running <= 1'b0;
    else if (!isOne)      running <= 1'b0;
    else if (stb.capLoad) running <= 1'b0;
    else if (startStb)    running <= 1'b1;
  end

  // wrap seen since last capture, resolved only by a capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pending <= 1'b0;
    else if (!capMode)    pending <= 1'b0;
    else if (stb.capLoad) pending <= 1'b0;
    else if (wrapNow)     pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wrapFlag <= 1'b0;
    else if (stb.capLoad) wrapFlag <= pending | wrapNow;
  end
endmodule

// File: rtl/capture_timer_dp.sv
module capture_timer_dp
  import capture_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       stb,
  output logic             cntMax,
  output logic [CNT_W-1:0] capReg
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntVal;

  assign cntMax = (cntVal == ALL_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cntVal <= '0;
    else if (stb.cntClr) cntVal <= '0;
    else if (stb.cntInc) cntVal <= cntVal + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           capReg <= '0;
    else if (stb.capLoad) capReg <= cntVal;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import capture_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             cntEn,
  input  logic             capStb,
  input  logic             startStb,
  output logic [CNT_W-1:0] capData,
  output logic [7:0]       status
);
  tmrStrobe_t stb;
  logic cntMax, wrapNow, wrapFlag, capLoad;

  capture_timer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cntEn(cntEn),
    .capStb(capStb), .startStb(startStb), .cntMax(cntMax),
    .stb(stb), .wrapNow(wrapNow), .wrapFlag(wrapFlag)
  );

  capture_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cntMax(cntMax), .capReg(capData)
  );

  assign capLoad = stb.capLoad;
  assign status  = {7'b0000000, wrapFlag};
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             capStb,
  input logic [CNT_W-1:0] capData,
  input logic [7:0]       status,
  input logic             capLoad,
  input logic             wrapNow
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:1] == 7'd0); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (status == 8'h00 && capData == '0)); // R3
  AST_FLAG_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    !capLoad |=> $stable(status)); // R4
  AST_SAME_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (capLoad && wrapNow) |=> (status[0] && capData == '1)); // R8
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b010 && mode != 3'b110 && capStb) |=> ($stable(status) && $stable(capData))); // R1
  AST_IDLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (capStb && !capLoad) |=> $stable(capData)); // R9
endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .capStb(capStb),
  .capData(capData), .status(status), .capLoad(capLoad), .wrapNow(wrapNow)
);

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;
  localparam int W = 10;
  localparam int WRAP = 1 << W;

  typedef struct {
    logic [W-1:0] data;
    logic         flag;
    string        req;
  } expItem_t;

  logic clk = 1'b0, rst_n = 1'b0, cntEn = 1'b0, capStb = 1'b0, startStb = 1'b0;
  logic [2:0] mode = 3'b010;
  logic [W-1:0] capData;
  logic [7:0] status;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  capture_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cntEn(cntEn),
    .capStb(capStb), .startStb(startStb), .capData(capData), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic capture(input logic [W-1:0] d, input logic f, input string req);
    expItem_t it;
    it.data = d; it.flag = f; it.req = req;
    expQ.push_back(it);
    capStb = 1'b1;
    @(negedge clk);
    capStb = 1'b0;
  endtask

  task automatic start();
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  // monitor: results due one cycle after the strobe edge
  always @(posedge clk) begin
    if (capStb && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      #3;
      check({it.req, " data"}, int'(capData), int'(it.data));
      check({it.req, " status"}, int'(status), int'({7'b0, it.flag}));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R3 reset status", int'(status), 0);
    check("R3 reset capData", int'(capData), 0);
    rst_n = 1'b1; cntEn = 1'b1; mode = 3'b010;
    idle(10);  capture(10'd10, 1'b0, "R7 first count");
    idle(5);   capture(10'd5, 1'b0, "R7 restart");
    cntEn = 1'b0; idle(20); cntEn = 1'b1;
    idle(3);   capture(10'd3, 1'b0, "R7 enable hold");
    idle(WRAP + 4);
    check("R4 flag after wrap", int'(status), 0);
    capture(10'd4, 1'b1, "R5 wrap then capture");
    check("R2 upper bits", int'(status[7:1]), 0);
    idle(7);   capture(10'd7, 1'b0, "R6 clear flag");
    idle(WRAP - 1); capture(10'h3FF, 1'b1, "R8 same edge wrap");
    idle(2);   capture(10'd2, 1'b0, "R6 clear after R8");
    idle(WRAP + 4);               // counter 4, wrap pending
    mode = 3'b000;
    capture(10'd2, 1'b0, "R1 ignored capture");   // counter -> 5
    mode = 3'b010;
    capture(10'd5, 1'b0, "R10 pending dropped");  // counter -> 0
    mode = 3'b110;
    idle(10);
    capture(10'd5, 1'b0, "R9 halted capture");
    start();
    idle(6);   capture(10'd6, 1'b0, "R9 single shot");
    idle(10);
    capture(10'd6, 1'b0, "R9 halted after shot");
    start();
    idle(WRAP + 3); capture(10'd3, 1'b1, "R5 single shot wrap");
    mode = 3'b011;
    capture(10'd3, 1'b1, "R1 flag kept");
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule